// File: doc/BRIEF.md
# Binary-to-Decimal Seven-Segment Readout

This block turns a binary integer into the drive for a row of seven-segment digits that show the same number in decimal. It has no clock and no state. The input width is a parameter, and 8, 16 and 20 bits are the main cases. The conversion is the shift-and-add-3 method, unrolled into a fixed array of small correction cells. No lookup memory is used. Each resulting BCD digit then passes through its own segment decoder.

When the signed option is set, the top input bit is the sign. A negative value is negated in two's complement before it enters the same converter, and a separate minus lamp lights. A third build option skips the conversion and shows the raw hexadecimal nibbles, with letters for ten to fifteen. The number of digits and the width of the most significant digit are derived from the largest value the chosen mode can present. For example, an 8-bit unsigned readout has three digits, and its hundreds digit carries only two live bits.

Top module: `bin2seg_readout`

## Requirements
- R1: In the decimal modes, nibble k of `digits_out` (bits 4k+3..4k, with k=0 the units) equals floor(M / 10^k) mod 10. Here M is the displayed magnitude: the input itself when unsigned, and its two's-complement absolute value when signed.
- R2: The digit count is the number of decimal digits in the largest magnitude of the mode. This gives 3 digits for 8 bits unsigned or signed, 5 for 16 bits signed and 7 for 20 bits unsigned, so 255 and 1048575 fill every digit.
- R3: The bits of the top digit above what its largest value needs read zero. For 8 bits unsigned this means `digits_out[11:10]` is always 0, and for 20 bits unsigned it means `digits_out[27:25]` is always 0.
- R4: In the decimal modes every nibble of `digits_out` is in the range 0 to 9.
- R5: `seg_out[7k+6:7k]` drives digit k, active high, with bit 0 = segment a through bit 6 = segment g. The patterns in g..a order are: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R6: Segment b (bit 1 of a digit) is off for both 5 and 6, so a 6 never appears as an 8.
- R7: With the signed option clear, `minus_out` is always 0.
- R8: With the signed option set, `minus_out` equals the input's top bit. A negative input shows the magnitude of its two's-complement value, and a non-negative input shows itself.
- R9: The most negative signed input shows its full magnitude 2^(WIDTH-1), with the minus lamp on. This is 128 at 8 bits and 32768 at 16 bits.
- R10: In hex mode, nibble k of `digits_out` is input bits 4k+3..4k and `minus_out` is 0. The letters in g..a order are A=1110111, b=1111100, C=0111001, d=1011110, E=1111001, F=1110001.
- R11: A zero input gives all-zero digits, with every digit showing the pattern for 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value_in | input | WIDTH | Binary value to display |
| digits_out | output | 4*DIGITS | BCD (or hex) digits, units in the low nibble |
| seg_out | output | 7*DIGITS | Segment drive, 7 bits per digit, a at the low bit |
| minus_out | output | 1 | Minus lamp for negative signed inputs |

## Verification
The checks assume that `value_in` is always a known value. They also assume WIDTH is at most 30, which keeps the magnitude bound and the powers of ten within 64-bit constant arithmetic. Because the block is purely combinational, the checks also assume the outputs are read only after the input has settled. The stimulus changes inputs just after a rising edge and reads the outputs at the falling edge, so every value it drives is fully defined. The stimulus uses the 8-, 12-, 16- and 20-bit builds, all inside that width limit, and sweeps every input of the small builds.

// File: rtl/bin2seg_readout.sv
module bin2seg_readout #(
  parameter int WIDTH = 8,
  parameter bit SIGNED_IN = 1'b0,
  parameter bit HEX_VIEW = 1'b0,
  localparam longint FULL = (longint'(1) << WIDTH) - 1,
  localparam longint MAXV = (SIGNED_IN && !HEX_VIEW) ? (longint'(1) << (WIDTH - 1)) : FULL,
  localparam int DIGITS = HEX_VIEW ? (WIDTH + 3) / 4 :
    1 + int'(MAXV >= 64'd10) + int'(MAXV >= 64'd100) + int'(MAXV >= 64'd1000)
      + int'(MAXV >= 64'd10000) + int'(MAXV >= 64'd100000) + int'(MAXV >= 64'd1000000)
      + int'(MAXV >= 64'd10000000) + int'(MAXV >= 64'd100000000) + int'(MAXV >= 64'd1000000000),
  localparam longint TOPW = longint'(10) ** (DIGITS - 1),
  localparam int TOP_BITS = HEX_VIEW ? WIDTH - 4 * (DIGITS - 1) : $clog2(MAXV / TOPW + 1),
  localparam int BW = 4 * DIGITS
) (
  input  logic [WIDTH-1:0]    value_in,
  output logic [BW-1:0]       digits_out,
  output logic [7*DIGITS-1:0] seg_out,
  output logic                minus_out
);

  function automatic logic [3:0] add3(input logic [3:0] n);
    logic ge5;
    ge5 = n[3] | (n[2] & (n[1] | n[0]));
    return {ge5,
            ge5 ? (n[3] & n[0]) : n[2],
            ge5 ? ~(n[1] ^ n[0]) : n[1],
            n[0] ^ ge5};
  endfunction

  function automatic logic [6:0] seg7(input logic [3:0] n);
    case (n)
      4'd0:  return 7'b0111111;
      4'd1:  return 7'b0000110;
      4'd2:  return 7'b1011011;
      4'd3:  return 7'b1001111;
      4'd4:  return 7'b1100110;
      4'd5:  return 7'b1101101;
      4'd6:  return 7'b1111101;
      4'd7:  return 7'b0000111;
      4'd8:  return 7'b1111111;
      4'd9:  return 7'b1101111;
      4'd10: return HEX_VIEW ? 7'b1110111 : 7'b0000000;
      4'd11: return HEX_VIEW ? 7'b1111100 : 7'b0000000;
      4'd12: return HEX_VIEW ? 7'b0111001 : 7'b0000000;
      4'd13: return HEX_VIEW ? 7'b1011110 : 7'b0000000;
      4'd14: return HEX_VIEW ? 7'b1111001 : 7'b0000000;
      default: return HEX_VIEW ? 7'b1110001 : 7'b0000000;
    endcase
  endfunction

  logic neg;
  assign minus_out = neg;

  if (HEX_VIEW) begin : g_hex
    assign neg = 1'b0;
    assign digits_out = BW'(value_in);
  end else begin : g_dec
    logic [WIDTH-1:0] mag;
    logic [BW-1:0] st [0:WIDTH];

    if (SIGNED_IN) begin : g_sgn
      assign neg = value_in[WIDTH-1];
      assign mag = neg ? (~value_in + 1'b1) : value_in;
    end else begin : g_uns
      assign neg = 1'b0;
      assign mag = value_in;
    end

    assign st[0] = '0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_step
      logic [BW-1:0] cor;
      for (genvar k = 0; k < DIGITS; k++) begin : g_nib
        if (((longint'(1) << i) - 1) >= (5 * (longint'(10) ** k))) begin : g_fix
          assign cor[4*k +: 4] = add3(st[i][4*k +: 4]);
        end else begin : g_pass
          assign cor[4*k +: 4] = st[i][4*k +: 4];
        end
      end
      assign st[i+1] = BW'({cor, mag[WIDTH-1-i]});
    end

    assign digits_out = st[WIDTH];
  end

  for (genvar k = 0; k < DIGITS; k++) begin : g_seg
    assign seg_out[7*k +: 7] = seg7(digits_out[4*k +: 4]);
  end

endmodule

// File: rtl/bin2seg_readout_chk.sv
module bin2seg_readout_chk #(
  parameter int WIDTH = 8,
  parameter bit SIGNED_IN = 1'b0,
  parameter bit HEX_VIEW = 1'b0,
  parameter int DIGITS = 3,
  parameter int TOP_BITS = 2
) (
  input logic [WIDTH-1:0]    value_in,
  input logic [4*DIGITS-1:0] digits_out,
  input logic [7*DIGITS-1:0] seg_out,
  input logic                minus_out
);

  always_comb begin
    assert_minus_src_R7: assert (!minus_out || (SIGNED_IN && !HEX_VIEW && value_in[WIDTH-1]))
      else $error("minus lamp lit without a negative signed input");
    assert_neg_nonzero_R8: assert (!minus_out || digits_out != '0)
      else $error("negative input shown as zero");
    if (!HEX_VIEW) begin
      assert_top_trim_R3: assert ((digits_out >> (4*(DIGITS-1) + TOP_BITS)) == '0)
        else $error("unused top digit bits set");
    end
    if (value_in == '0) begin
      assert_zero_in_R11: assert (digits_out == '0 && !minus_out)
        else $error("zero input not shown as zero");
    end
    for (int k = 0; k < DIGITS; k++) begin
      if (!HEX_VIEW) begin
        assert_bcd_range_R4: assert (digits_out[4*k +: 4] <= 4'd9)
          else $error("digit %0d out of decimal range", k);
      end
      if (digits_out[4*k +: 4] == 4'd5 || digits_out[4*k +: 4] == 4'd6) begin
        assert_seg_b_off_R6: assert (!seg_out[7*k + 1])
          else $error("segment b lit on digit %0d showing 5 or 6", k);
      end
    end
  end

endmodule

bind bin2seg_readout bin2seg_readout_chk #(
  .WIDTH(WIDTH), .SIGNED_IN(SIGNED_IN), .HEX_VIEW(HEX_VIEW),
  .DIGITS(DIGITS), .TOP_BITS(TOP_BITS)
) u_chk (
  .value_in(value_in), .digits_out(digits_out),
  .seg_out(seg_out), .minus_out(minus_out)
);

// File: tb/sim_bin2seg_readout.sv
module sim_bin2seg_readout;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0]  in0, in1;
  logic [19:0] in2;
  logic [15:0] in3;
  logic [11:0] in4;
  logic [11:0] d0, d1, d4;
  logic [27:0] d2;
  logic [19:0] d3;
  logic [20:0] s0, s1, s4;
  logic [48:0] s2;
  logic [34:0] s3;
  logic m0, m1, m2, m3, m4;

  bin2seg_readout #(.WIDTH(8))                       u0 (.value_in(in0), .digits_out(d0), .seg_out(s0), .minus_out(m0));
  bin2seg_readout #(.WIDTH(8),  .SIGNED_IN(1'b1))    u1 (.value_in(in1), .digits_out(d1), .seg_out(s1), .minus_out(m1));
  bin2seg_readout #(.WIDTH(20))                      u2 (.value_in(in2), .digits_out(d2), .seg_out(s2), .minus_out(m2));
  bin2seg_readout #(.WIDTH(16), .SIGNED_IN(1'b1))    u3 (.value_in(in3), .digits_out(d3), .seg_out(s3), .minus_out(m3));
  bin2seg_readout #(.WIDTH(12), .HEX_VIEW(1'b1))     u4 (.value_in(in4), .digits_out(d4), .seg_out(s4), .minus_out(m4));

  function automatic logic [6:0] pat(input logic [3:0] n, input bit hex);
    case (n)
      4'd0: pat = 7'b0111111;  4'd1: pat = 7'b0000110;
      4'd2: pat = 7'b1011011;  4'd3: pat = 7'b1001111;
      4'd4: pat = 7'b1100110;  4'd5: pat = 7'b1101101;
      4'd6: pat = 7'b1111101;  4'd7: pat = 7'b0000111;
      4'd8: pat = 7'b1111111;  4'd9: pat = 7'b1101111;
      4'd10: pat = hex ? 7'b1110111 : 7'b0;
      4'd11: pat = hex ? 7'b1111100 : 7'b0;
      4'd12: pat = hex ? 7'b0111001 : 7'b0;
      4'd13: pat = hex ? 7'b1011110 : 7'b0;
      4'd14: pat = hex ? 7'b1111001 : 7'b0;
      default: pat = hex ? 7'b1110001 : 7'b0;
    endcase
  endfunction

  function automatic logic [63:0] dec_digits(input longint m, input int nd);
    logic [63:0] r = '0;
    for (int k = 0; k < nd; k++) begin
      r[4*k +: 4] = 4'(m % 10);
      m = m / 10;
    end
    return r;
  endfunction

  function automatic logic [63:0] segs_of(input logic [63:0] nib, input int nd, input bit hex);
    logic [63:0] r = '0;
    for (int k = 0; k < nd; k++) r[7*k +: 7] = pat(nib[4*k +: 4], hex);
    return r;
  endfunction

  function automatic bit all_dec(input logic [63:0] nib, input int nd);
    bit ok = 1'b1;
    for (int k = 0; k < nd; k++) if (nib[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_u2(input longint v);
    @(posedge clk);
    in2 = 20'(v);
    @(negedge clk);
    eq("R1 u2 digits", 64'(d2), dec_digits(v, 7));
    eq("R5 u2 segments", 64'(s2), segs_of(dec_digits(v, 7), 7, 1'b0));
    eq("R4 u2 nibble range", 64'(all_dec(64'(d2), 7)), 64'd1);
    eq("R3 u2 top bits", 64'(d2[27:25]), 64'd0);
    eq("R7 u2 minus", 64'(m2), 64'd0);
  endtask

  task automatic run_u3(input int v);
    longint mag;
    mag = (v >= 32768) ? longint'(65536 - v) : longint'(v);
    @(posedge clk);
    in3 = 16'(v);
    @(negedge clk);
    eq("R8 u3 digits", 64'(d3), dec_digits(mag, 5));
    eq("R8 u3 minus", 64'(m3), 64'(v >= 32768));
    eq("R5 u3 segments", 64'(s3), segs_of(dec_digits(mag, 5), 5, 1'b0));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    in0 = '0; in1 = '0; in2 = '0; in3 = '0; in4 = '0;
    lcg = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);

    eq("R11 u0 zero digits", 64'(d0), 64'd0);
    eq("R11 u0 zero segments", 64'(s0), {43'd0, 21'b0111111_0111111_0111111});
    eq("R11 u2 zero segments", 64'(s2), segs_of(64'd0, 7, 1'b0));
    eq("R11 u1 zero minus", 64'(m1), 64'd0);

    for (int v = 0; v < 256; v++) begin
      longint mg;
      mg = (v >= 128) ? longint'(256 - v) : longint'(v);
      @(posedge clk);
      in0 = 8'(v);
      in1 = 8'(v);
      @(negedge clk);
      eq("R1 u0 digits", 64'(d0), dec_digits(longint'(v), 3));
      eq("R5 u0 segments", 64'(s0), segs_of(dec_digits(longint'(v), 3), 3, 1'b0));
      eq("R3 u0 hundreds upper bits", 64'(d0[11:10]), 64'd0);
      eq("R7 u0 minus", 64'(m0), 64'd0);
      eq("R8 u1 digits", 64'(d1), dec_digits(mg, 3));
      eq("R8 u1 minus", 64'(m1), 64'(v >= 128));
      eq("R5 u1 segments", 64'(s1), segs_of(dec_digits(mg, 3), 3, 1'b0));
      if (v == 5 || v == 6) begin
        eq("R6 u0 segment b off", 64'(s0[1]), 64'd0);
        eq("R6 u0 units pattern", 64'(s0[6:0]), (v == 6) ? 64'b1111101 : 64'b1101101);
      end
      if (v == 255) eq("R2 u0 three digits", 64'(d0), 64'h255);
      if (v == 128) begin
        eq("R9 u1 most negative", 64'(d1), 64'h128);
        eq("R9 u1 minus", 64'(m1), 64'd1);
      end
    end

    run_u2(1048575);
    eq("R2 u2 seven digits", 64'(d2), 64'h1048575);
    run_u2(0); run_u2(9); run_u2(10); run_u2(99); run_u2(100);
    run_u2(999999); run_u2(1000000); run_u2(65536); run_u2(524288);
    for (int n = 0; n < 3000; n++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      run_u2(longint'(lcg[27:8]));
    end

    run_u3(32768);
    eq("R9 u3 most negative", 64'(d3), 64'h32768);
    run_u3(0); run_u3(32767); run_u3(65535); run_u3(10000); run_u3(55536);
    for (int n = 0; n < 2000; n++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      run_u3(int'(lcg[23:8]));
    end

    for (int v = 0; v < 4096; v++) begin
      @(posedge clk);
      in4 = 12'(v);
      @(negedge clk);
      eq("R10 u4 hex digits", 64'(d4), 64'(v));
      eq("R10 u4 hex segments", 64'(s4), segs_of(64'(v), 3, 1'b1));
      eq("R10 u4 minus", 64'(m4), 64'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule